// File: doc/BRIEF.md
# Multi-Mode Clock-Enable Divider

This block thins a stream of single-cycle clock-enable pulses. Each pulse on `en_in` is one tick of a source clock domain, and the block passes one of every N of those ticks through to `en_out`. N comes from a bit field of a 32-bit control word. How the field is turned into N is fixed at elaboration by the `MODE` parameter.

There are four modes. A constant ratio ignores the field. The field plus one gives the ratio directly. The field plus one can also be doubled. In the last mode, the field is the exponent of a power of two.

Because `en_out` is a subset of the `en_in` pulses and appears in the same cycle, dividers can be chained with no added latency. A system-rate divider can feed a bus-rate divider, which can in turn feed several peripheral dividers. The control word can change at any time. A new ratio is taken up only when a division period starts, so no output period is ever cut short.

Top module: `clkdiv_top`

## Requirements
- R1: With `MODE` = constant, `en_out` fires once for every `CONST_DIV` pulses of `en_in`, whatever the control word holds.
- R2: With `MODE` = field-plus-one, the ratio is F+1. F is `ctrl_word[FIELD_LSB +: FIELD_W]` read as an unsigned value.
- R3: With `MODE` = doubled, the ratio is 2×(F+1).
- R4: With `MODE` = shift, the ratio is 2 to the power F.
- R5: In field-plus-one mode with F = 0, every `en_in` pulse is passed to `en_out`.
- R6: `en_out` is high only in a cycle where `en_in` is high. The output appears in the same cycle, so it can drive the `en_in` of another instance directly.
- R7: The ratio of a period is the one decoded at that period's first input pulse. Changes to the field later in the period do not change the period's length.
- R8: Control-word bits outside the selected field have no effect on `en_out`.
- R9: After `rst_n` is released, the first division period begins with the first `en_in` pulse. Cycles without an `en_in` pulse do not advance the divider.
- R10: When one instance drives another, the overall ratio is the product of the two stage ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_in | input | 1 | Source enable pulse stream |
| ctrl_word | input | 32 | Control word holding the ratio field |
| en_out | output | 1 | Divided enable pulse, a subset of `en_in` |

## Verification
The bench targets the period in which the field changes mid-way. A design that adopted the new ratio at once would end that period early, or run past it. A zero field in field-plus-one mode would expose an off-by-one: such a divider would emit every second pulse, or none. Toggling bits outside the field would show up as period jitter in a design that decoded the wrong slice. A chained pair with gapped input enables checks that idle cycles do not count and that the stage ratios multiply.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic [1:0] {
    DIV_CONST  = 2'd0,
    DIV_PLUS1  = 2'd1,
    DIV_DOUBLE = 2'd2,
    DIV_SHIFT  = 2'd3
  } div_mode_e;

  // Largest ratio a mode can produce for the given field width.
  function automatic int ratio_max(div_mode_e m, int cdiv, int w);
    case (m)
      DIV_CONST:  return (cdiv < 1) ? 1 : cdiv;
      DIV_PLUS1:  return 1 << w;
      DIV_DOUBLE: return 2 << w;
      default:    return 1 << ((1 << w) - 1);
    endcase
  endfunction

  function automatic int ratio_bits(div_mode_e m, int cdiv, int w);
    return $clog2(ratio_max(m, cdiv, w) + 1);
  endfunction

endpackage

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio
  import clkdiv_pkg::*;
#(
  parameter div_mode_e MODE      = DIV_PLUS1,
  parameter int        CONST_DIV = 2,
  parameter int        FIELD_LSB = 0,
  parameter int        FIELD_W   = 3,
  parameter int        RW        = 4
) (
  input  logic [31:0]   ctrl,
  output logic [RW-1:0] ratio
);

  logic [FIELD_W-1:0] fld;
  logic               unused_ctrl;

  assign fld         = ctrl[FIELD_LSB +: FIELD_W];
  assign unused_ctrl = ^ctrl;

  generate
    if (MODE == DIV_CONST) begin : g_const
      localparam int CD = (CONST_DIV < 1) ? 1 : CONST_DIV;
      logic unused_fld;
      assign unused_fld = ^fld;
      assign ratio = RW'(CD);
    end else if (MODE == DIV_PLUS1) begin : g_plus1
      assign ratio = RW'(fld) + RW'(1);
    end else if (MODE == DIV_DOUBLE) begin : g_double
      assign ratio = (RW'(fld) + RW'(1)) << 1;
    end else begin : g_shift
      assign ratio = RW'(1) << fld;
    end
  endgenerate

endmodule

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_in,
  input  logic [RW-1:0] ratio_live,
  output logic          en_out,
  output logic [RW-1:0] cnt,
  output logic [RW-1:0] held
);

  logic [RW-1:0] eff;
  logic          term;

  // At a period start the live ratio is used; inside a period the latched one.
  assign eff    = (cnt == '0) ? ratio_live : held;
  assign term   = (cnt == eff - RW'(1));
  assign en_out = en_in & term;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= RW'(1);
    end else if (en_in) begin
      if (cnt == '0) held <= ratio_live;
      cnt <= term ? '0 : cnt + RW'(1);
    end
  end

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter div_mode_e MODE      = DIV_PLUS1,
  parameter int        CONST_DIV = 2,
  parameter int        FIELD_LSB = 0,
  parameter int        FIELD_W   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_in,
  input  logic [31:0] ctrl_word,
  output logic        en_out
);

  localparam int RW = ratio_bits(MODE, CONST_DIV, FIELD_W);

  logic [RW-1:0] ratio_live;
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] held_q;

  clkdiv_ratio #(
    .MODE(MODE), .CONST_DIV(CONST_DIV), .FIELD_LSB(FIELD_LSB),
    .FIELD_W(FIELD_W), .RW(RW)
  ) u_ratio (
    .ctrl  (ctrl_word),
    .ratio (ratio_live)
  );

  clkdiv_count #(.RW(RW)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_in      (en_in),
    .ratio_live (ratio_live),
    .en_out     (en_out),
    .cnt        (cnt_q),
    .held       (held_q)
  );

endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_in,
  input logic          en_out,
  input logic [RW-1:0] cnt,
  input logic [RW-1:0] held
);

  // R6
  out_needs_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_out |-> en_in);

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_in |=> $stable(cnt));

  // R7
  held_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && $past(cnt) != '0) |-> $stable(held));

  // R7
  out_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_out |=> (cnt == '0));

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> (cnt < held));

endmodule

bind clkdiv_top clkdiv_chk #(.RW(RW)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .en_in  (en_in),
  .en_out (en_out),
  .cnt    (cnt_q),
  .held   (held_q)
);

// File: tb/sim_clkdiv_top.sv
`timescale 1ns/1ps
module sim_clkdiv_top;
  import clkdiv_pkg::*;

  localparam int NI = 5;
  // per-instance mode: 0 const, 1 plus1, 2 double, 3 shift
  localparam int MD [NI]  = '{1, 2, 3, 0, 1};
  localparam int LSB [NI] = '{0, 4, 8, 0, 12};
  localparam int WID [NI] = '{3, 3, 3, 3, 2};
  localparam int CDV = 3;
  localparam string TAG [NI] = '{"R2", "R3", "R4", "R1", "R10"};

  logic clk = 0;
  logic rst_n = 0;
  logic en_in = 0;
  logic [31:0] ctrl = 0;
  logic [NI-1:0] outs;

  always #5 clk = ~clk;

  clkdiv_top #(.MODE(DIV_PLUS1), .FIELD_LSB(0), .FIELD_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .ctrl_word(ctrl), .en_out(outs[0]));
  clkdiv_top #(.MODE(DIV_DOUBLE), .FIELD_LSB(4), .FIELD_W(3)) u1 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .ctrl_word(ctrl), .en_out(outs[1]));
  clkdiv_top #(.MODE(DIV_SHIFT), .FIELD_LSB(8), .FIELD_W(3)) u2 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .ctrl_word(ctrl), .en_out(outs[2]));
  clkdiv_top #(.MODE(DIV_CONST), .CONST_DIV(CDV), .FIELD_LSB(0), .FIELD_W(3)) u3 (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .ctrl_word(ctrl), .en_out(outs[3]));
  clkdiv_top #(.MODE(DIV_PLUS1), .FIELD_LSB(12), .FIELD_W(2)) u4 (
    .clk(clk), .rst_n(rst_n), .en_in(outs[0]), .ctrl_word(ctrl), .en_out(outs[4]));

  int n_chk = 0;
  int n_bad = 0;
  int mcnt [NI];
  int mheld [NI];

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_ratio(int i, logic [31:0] c);
    int f;
    f = int'((c >> LSB[i]) & ((32'd1 << WID[i]) - 1));
    case (MD[i])
      0: return CDV;
      1: return f + 1;
      2: return 2 * (f + 1);
      default: return 1 << f;
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < NI; i++) begin
      mcnt[i] = 0;
      mheld[i] = 1;
    end
  endtask

  // Drive one cycle, compare every instance with the model, advance the model.
  task automatic step(bit en, logic [31:0] c);
    bit ein [NI];
    bit exp [NI];
    int eff;
    @(negedge clk);
    en_in = en;
    ctrl = c;
    #1;
    for (int i = 0; i < NI; i++) begin
      ein[i] = (i == 4) ? exp[0] : en;
      eff = (mcnt[i] == 0) ? exp_ratio(i, c) : mheld[i];
      exp[i] = ein[i] && (mcnt[i] == eff - 1);
      chk(outs[i] == exp[i], TAG[i], int'(outs[i]), int'(exp[i]));
      if (ein[i]) begin
        if (mcnt[i] == 0) mheld[i] = exp_ratio(i, c);
        mcnt[i] = exp[i] ? 0 : mcnt[i] + 1;
      end
    end
    // R6: no output without an input pulse
    chk(!(outs[3] && !en), "R6", int'(outs[3]), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    en_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_clear();
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pulses;
    logic [31:0] c;
    void'($urandom(32'd20240611));
    model_clear();
    do_reset();

    // R9: reset state, idle cycles produce nothing and do not advance
    #1;
    chk(outs == '0, "R9", int'(outs), 0);
    for (int k = 0; k < 4; k++) step(1'b0, 32'h0000_0005);
    // R9: first pulse after reset with ratio 6 must not fire
    step(1'b1, 32'h0000_0005);
    chk(outs[0] == 1'b0, "R9", int'(outs[0]), 0);

    // R7: period of 6 started; change field to 1 mid-period
    pulses = 1;
    for (int k = 0; k < 20 && !outs[0]; k++) begin
      step(1'b1, (pulses >= 2) ? 32'h0000_0001 : 32'h0000_0005);
      pulses++;
      if (outs[0]) chk(pulses == 6, "R7", pulses, 6);
    end
    // next period uses ratio 2
    step(1'b1, 32'h1);
    chk(outs[0] == 1'b0, "R7", int'(outs[0]), 0);
    step(1'b1, 32'h1);
    chk(outs[0] == 1'b1, "R7", int'(outs[0]), 1);

    // R5: field zero passes every pulse
    do_reset();
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 32'h0000_0000);
      chk(outs[0] == 1'b1, "R5", int'(outs[0]), 1);
    end

    // R8: toggle bits outside u0 field; spacing must stay at ratio 4
    do_reset();
    pulses = 0;
    for (int k = 0; k < 16; k++) begin
      step(1'b1, {$urandom} & 32'hFFFF_FFF8 | 32'h3);
      pulses++;
      chk(outs[0] == (pulses % 4 == 0), "R8", int'(outs[0]), int'(pulses % 4 == 0));
    end

    // R10: chained pair, u0 ratio 2, u4 ratio 3 -> every 6th pulse
    do_reset();
    pulses = 0;
    for (int k = 0; k < 24; k++) begin
      step(1'b1, 32'h0000_2001);
      pulses++;
      chk(outs[4] == (pulses % 6 == 0), "R10", int'(outs[4]), int'(pulses % 6 == 0));
    end

    // Random: gapped enables, occasional control changes (R1..R4, R6..R10)
    do_reset();
    c = $urandom;
    for (int k = 0; k < 6000; k++) begin
      if ($urandom % 40 == 0) c = $urandom;
      step(($urandom % 4) != 0, c);
      if (k == 3000) do_reset();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule